// File: doc/BRIEF.md
# Flash Bank Chip-Erase Command Controller

This block is the device-side command logic of a NOR-style flash bank. It watches write cycles on the bus, follows the unlock handshake, and on a complete chip-erase request it runs a self-timed erase of a small internal array. The erase has two phases. First every word is driven to all zeros, then every word is set to the erased value of all ones. Each word takes a fixed, parameterised number of clock cycles in each phase. The host only has to start the erase; it provides no timing or control while the erase runs.

The bank also accepts a four-write word-program command. The host uses it to load data that a later erase then clears. While the erase is running, the read port does not return array data: it returns a status byte that the host polls. Bus writes made during that time are dropped. A hardware reset stops the erase on the spot. Any words already handled keep their new value and the rest keep their old contents.

Top module: `flash_erase_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `busy` is 0 and `rdata` is 0x00.
- R2: The erase starts only after six writes, in this order, with the address compared on its low 11 bits: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10). `busy` is 1 from the clock edge that takes the sixth write.
- R3: A write that does not match the next expected step sends the decoder back to its idle state. A write that would only have matched the step after that does not move the sequence on.
- R4: `busy` stays high for exactly 2*DEPTH*CYC_PER_WORD cycles. Once it falls, every array word reads 0xFF.
- R5: In the first phase, words are handled in ascending index order. Word i becomes 0x00 at the end of its CYC_PER_WORD-cycle slot. All words reach 0x00 before any word is erased.
- R6: A read accepted while `busy` is 1 returns a status byte. Bit 7 is 0. Bits 6 and 2 are equal and read 0 on the first status read after the erase starts. They invert on each later status read. All other bits are 0, so successive status reads give 0x00, 0x44, 0x00, ...
- R7: Writes made while `busy` is 1 have no effect. A program sequence changes no word, and a second erase sequence does not lengthen `busy`.
- R8: Pulling `rst_n` low during an erase clears `busy` at once. The array keeps every word written so far, and reads after the reset return array data.
- R9: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0) followed by (A,D) set word A[IDX_W-1:0] to its old value AND D. `rdata` shows the addressed word one cycle after `rd_en` is taken.
- R10: When the erase ends, the bank returns to read mode with the decoder idle. A lone (0x555,0x10) write then starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hardware reset, asynchronous, active low; aborts an erase |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | 8 | Bus write data |
| rd_en | input | 1 | Read request, result registered into `rdata` |
| rdata | output | 8 | Array word, or status byte while busy |
| busy | output | 1 | Embedded erase in progress |

## Verification
Three results are due at fixed distances from their stimulus. `busy` rises on the edge that takes the sixth erase write. `rdata` is valid one edge after `rd_en` is taken. Word i of the zero phase is written 3*(i+1) edges after the start (with CYC_PER_WORD = 3). The bench drives inputs on falling edges and samples on the next falling edge, so each check falls half a cycle after the edge that produced the result. The erase length is measured by counting the falling edges at which `busy` is high. The reset abort is applied after exactly seven edges, which gives a known split: words 0 and 1 already zero, the rest untouched.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int BYTE_W = 8;
    localparam int KEY_W  = 11;

    localparam logic [KEY_W-1:0]  KEY_ADDR_A = 11'h555;
    localparam logic [KEY_W-1:0]  KEY_ADDR_B = 11'h2AA;
    localparam logic [BYTE_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [BYTE_W-1:0] OP_SETUP   = 8'h80;
    localparam logic [BYTE_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [BYTE_W-1:0] WORD_BLANK = 8'hFF;
    localparam logic [BYTE_W-1:0] WORD_ZERO  = 8'h00;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_KEY1,
        CS_KEY2,
        CS_ARMED,
        CS_KEY3,
        CS_KEY4,
        CS_PROG
    } cmd_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ZERO,
        PH_BLANK
    } erase_phase_e;

    typedef struct packed {
        cmd_state_e st;
    } dec_regs_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              tog;
    } rd_regs_t;

endpackage

// File: rtl/fe_cmd_decoder.sv
module fe_cmd_decoder
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    output logic              erase_go,
    output logic              prog_we,
    output logic [IDX_W-1:0]  prog_idx,
    output logic [BYTE_W-1:0] prog_data
);

    dec_regs_t q, d;
    logic hit_a, hit_b;

    assign hit_a = (addr[KEY_W-1:0] == KEY_ADDR_A);
    assign hit_b = (addr[KEY_W-1:0] == KEY_ADDR_B);

    always_comb begin
        d         = q;
        erase_go  = 1'b0;
        prog_we   = 1'b0;
        prog_idx  = addr[IDX_W-1:0];
        prog_data = wdata;
        if (busy) begin
            d.st = CS_IDLE;
        end else if (wr_en) begin
            d.st = CS_IDLE;
            unique case (q.st)
                CS_IDLE:  if (hit_a && wdata == KEY_DATA_A) d.st = CS_KEY1;
                CS_KEY1:  if (hit_b && wdata == KEY_DATA_B) d.st = CS_KEY2;
                CS_KEY2: begin
                    if (hit_a && wdata == OP_SETUP)        d.st = CS_ARMED;
                    else if (hit_a && wdata == OP_PROGRAM) d.st = CS_PROG;
                end
                CS_ARMED: if (hit_a && wdata == KEY_DATA_A) d.st = CS_KEY3;
                CS_KEY3:  if (hit_b && wdata == KEY_DATA_B) d.st = CS_KEY4;
                CS_KEY4:  if (hit_a && wdata == OP_CHIP)    erase_go = 1'b1;
                CS_PROG:  prog_we = 1'b1;
                default:  d.st = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CS_IDLE};
        else        q <= d;
    end

endmodule

// File: rtl/fe_erase_engine.sv
module fe_erase_engine
    import flash_erase_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int CYC_PER_WORD = 3,
    parameter int IDX_W        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [BYTE_W-1:0] mem_wdata
);

    localparam int CNT_W = $clog2(CYC_PER_WORD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_WORD - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        erase_phase_e     phase;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } eng_regs_t;

    eng_regs_t q, d;

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_idx   = q.idx;
        mem_wdata = (q.phase == PH_ZERO) ? WORD_ZERO : WORD_BLANK;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_ZERO;
                    d.idx   = '0;
                    d.cnt   = '0;
                end
            end
            PH_ZERO, PH_BLANK: begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt  = '0;
                    mem_we = 1'b1;
                    if (q.idx == IDX_LAST) begin
                        d.idx   = '0;
                        d.phase = (q.phase == PH_ZERO) ? PH_BLANK : PH_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    assign busy = (q.phase != PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, idx: '0, cnt: '0};
        else        q <= d;
    end

endmodule

// File: rtl/fe_array.sv
module fe_array
    import flash_erase_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              and_mode,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rword
);

    logic [BYTE_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [BYTE_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(g)) begin
                cell_q <= and_mode ? (cell_q & wdata) : wdata;
            end
        end
        assign words[g] = cell_q;
    end

    assign rword = words[ridx];

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DEPTH        = 16,
    parameter int CYC_PER_WORD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              busy
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              erase_go, prog_we;
    logic [IDX_W-1:0]  prog_idx, eng_idx, arr_widx;
    logic [BYTE_W-1:0] prog_data, eng_wdata, arr_wdata, arr_rword;
    logic              eng_we, arr_we, arr_and;
    logic              eng_busy;

    fe_cmd_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (eng_busy),
        .erase_go (erase_go),
        .prog_we  (prog_we),
        .prog_idx (prog_idx),
        .prog_data(prog_data)
    );

    fe_erase_engine #(.DEPTH(DEPTH), .CYC_PER_WORD(CYC_PER_WORD), .IDX_W(IDX_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (erase_go),
        .busy     (eng_busy),
        .mem_we   (eng_we),
        .mem_idx  (eng_idx),
        .mem_wdata(eng_wdata)
    );

    always_comb begin
        arr_we    = eng_we | prog_we;
        arr_and   = !eng_we;
        arr_widx  = eng_we ? eng_idx   : prog_idx;
        arr_wdata = eng_we ? eng_wdata : prog_data;
    end

    fe_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_arr (
        .clk     (clk),
        .we      (arr_we),
        .and_mode(arr_and),
        .widx    (arr_widx),
        .wdata   (arr_wdata),
        .ridx    (addr[IDX_W-1:0]),
        .rword   (arr_rword)
    );

    rd_regs_t rq, rd;

    always_comb begin
        rd = rq;
        if (erase_go) rd.tog = 1'b0;
        if (rd_en) begin
            if (eng_busy) begin
                rd.rdata = {~WORD_BLANK[7], rq.tog, 3'b000, rq.tog, 2'b00};
                rd.tog   = ~rq.tog;
            end else begin
                rd.rdata = arr_rword;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq <= '{rdata: '0, tog: 1'b0};
        else        rq <= rd;
    end

    assign rdata = rq.rdata;
    assign busy  = eng_busy;

endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int ADDR_W       = 11,
    parameter int DEPTH        = 16,
    parameter int CYC_PER_WORD = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic              busy
);

    localparam int TOTAL = 2 * DEPTH * CYC_PER_WORD;

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R2: erase only begins on the edge of the final command write
    assert_erase_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_en) && $past(addr[10:0]) == 11'h555 && $past(wdata) == 8'h10));

    // R4: exact erase length
    assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == TOTAL));

    // R7: writes during the erase never stretch it
    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < TOTAL));

    // R6: status byte layout
    assert_status_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy)) |->
            (rdata[7] == 1'b0 && rdata[6] == rdata[2] && (rdata & 8'hBB) == 8'h00));

    // R1, R8: reset clears the busy flag and the read register
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!busy && rdata == 8'h00));

endmodule

bind flash_erase_ctl fe_checker #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CYC_PER_WORD(CYC_PER_WORD)
) u_fe_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .busy(busy)
);

// File: tb/flash_erase_ctl_bench.sv
module flash_erase_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CPW        = 3;
    localparam int ERASE_CYC  = 2 * DEPTH * CPW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int busy_cnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_erase_ctl #(.ADDR_W(11), .DEPTH(DEPTH), .CYC_PER_WORD(CPW)) u_flash_erase_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            report();
            $finish;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic erase_seq();
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h10);
    endtask

    task automatic prog_seq(input logic [10:0] a, input logic [7:0] d);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // entry: {op[1:0], addr[10:0], data[7:0], expect[7:0]}; op 0 write, 1 read-compare, 2 wait idle
    localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OI = 2'd2;
    localparam int NV = 33;
    localparam logic [28:0] VEC [NV] = '{
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'h80, 8'h00},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'h10, 8'h00},
        {OI, 11'h000, 8'h00, 8'h00},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'hA0, 8'h00},
        {OW, 11'h000, 8'h3C, 8'h00},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'hA0, 8'h00},
        {OW, 11'h001, 8'hA5, 8'h00},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'hA0, 8'h00},
        {OW, 11'h002, 8'h96, 8'h00},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'hA0, 8'h00},
        {OW, 11'h003, 8'h5A, 8'h00},
        {ORD, 11'h000, 8'h00, 8'h3C}, {ORD, 11'h001, 8'h00, 8'hA5}, {ORD, 11'h002, 8'h00, 8'h96},
        {ORD, 11'h003, 8'h00, 8'h5A}, {ORD, 11'h007, 8'h00, 8'hFF},
        {OW, 11'h555, 8'hAA, 8'h00}, {OW, 11'h2AA, 8'h55, 8'h00}, {OW, 11'h555, 8'hA0, 8'h00},
        {OW, 11'h000, 8'hF0, 8'h00},
        {ORD, 11'h000, 8'h00, 8'h30}
    };

    initial begin
        logic [7:0] r;

        repeat (3) @(negedge clk);
        check(int'(busy), 0, "R1 busy in reset");
        check(int'(rdata), 8'h00, "R1 rdata in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(busy), 0, "R1 busy after reset");

        // table walk: blank the array, program words, read back (R9)
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            case (v[28:27])
                OW:  bus_wr(v[26:16], v[15:8]);
                ORD: begin bus_rd(v[26:16], r); check(int'(r), int'(v[7:0]), "R9 table read"); end
                default: wait_idle();
            endcase
        end

        // R3: wrong fifth write, then the final erase write alone
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h54); bus_wr(11'h555, 8'h10);
        check(int'(busy), 0, "R3 broken erase sequence");
        // R3: program setup at wrong address, data write must not land
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h2AA, 8'hA0);
        bus_wr(11'h001, 8'h00);
        bus_rd(11'h001, r);
        check(int'(r), 8'hA5, "R3 broken program sequence");

        // R2, R6, R7, R4: full erase with status polling and ignored writes
        busy_cnt = 0;
        erase_seq();
        check(int'(busy), 1, "R2 busy after sixth write");
        bus_rd(11'h004, r); check(int'(r), 8'h00, "R6 first status");
        bus_rd(11'h004, r); check(int'(r), 8'h44, "R6 second status");
        bus_rd(11'h004, r); check(int'(r), 8'h00, "R6 third status");
        prog_seq(11'h002, 8'h00);
        erase_seq();
        wait_idle();
        check(busy_cnt, ERASE_CYC, "R4 erase length (R7 no restart)");
        for (int w = 0; w < DEPTH; w++) begin
            bus_rd(11'(w), r);
            check(int'(r), 8'hFF, (w == 2) ? "R7 word after ignored program" : "R4 erased word");
        end

        // R10: decoder idle after completion
        bus_wr(11'h555, 8'h10);
        check(int'(busy), 0, "R10 lone erase opcode");
        bus_rd(11'h003, r);
        check(int'(r), 8'hFF, "R10 read mode after erase");

        // R8, R5: abort after seven edges: words 0 and 1 zeroed, others intact
        prog_seq(11'h000, 8'h3C); prog_seq(11'h001, 8'hA5);
        prog_seq(11'h002, 8'h96); prog_seq(11'h003, 8'h5A);
        erase_seq();
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(int'(busy), 0, "R8 busy cleared by reset");
        check(int'(rdata), 8'h00, "R1 rdata during abort reset");
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(11'h000, r); check(int'(r), 8'h00, "R5 word0 zeroed");
        bus_rd(11'h001, r); check(int'(r), 8'h00, "R5 word1 zeroed");
        bus_rd(11'h002, r); check(int'(r), 8'h96, "R8 word2 kept");
        bus_rd(11'h003, r); check(int'(r), 8'h5A, "R8 word3 kept");

        // R9: program after abort, AND with old contents
        prog_seq(11'h002, 8'h0F);
        bus_rd(11'h002, r); check(int'(r), 8'h06, "R9 program ANDs data");

        report();
        $finish;
    end

endmodule